// File: doc/BRIEF.md
# Multi-Mode Timer / Event Counter

This block is a preloadable up-counter that serves three functions selected by software: a periodic interval timer driven by one of several internal tick sources, an event counter that advances on a chosen edge of an external pin, and a pulse-width meter. The pulse-width meter accumulates internal ticks only while the pin sits between a programmable start edge and the opposite stop edge. Software programs a control register, a preload register and the counter itself through a simple synchronous write port, and reads them back through a combinational read port.

The counter holds every operating mode behind a single enable bit. When the count passes its all-ones value it does not wrap to zero. It reloads from the preload register, keeps running, and sets a sticky interrupt flag if the interrupt enable input allows it. The external pin and the two slow tick inputs go through a synchronizer before any edge is detected, so all three may be fully asynchronous to the system clock.

Top module: `mtc_top`

## Requirements
- R1: After reset, the control register, preload register and counter all read 0, and `irq_req` is 0.
- R2: The control register at address 0 holds mode in bits 7:6, enable in bit 4, event-edge select in bit 3 and pulse-edge select in bit 2. Bits 5, 1 and 0 always read 0, whatever was written.
- R3: With mode 00, the counter never advances, even with enable set and activity on every input.
- R4: With the enable bit at 0, the count holds in every mode.
- R5: In mode 01 (event), the count advances by one for each rising edge of `ext_in` when bit 3 is 0, and for each falling edge when bit 3 is 1. The new value is visible three clock edges after the pin changes.
- R6: In mode 10 (timer), `src_sel` picks the tick source. Value 0 advances the count every clock, value 1 every fourth clock, value 2 on each high-to-low transition of `rtc_in`, and value 3 on each high-to-low transition of `tbase_in`.
- R7: In mode 11 with bit 2 set, counting starts on a rising edge of `ext_in` and stops on the next falling edge. With `src_sel` 0, a high pulse of W clocks adds exactly W.
- R8: In mode 11 with bit 2 clear, counting starts on a falling edge and stops on the next rising edge. With `src_sel` 0, a low pulse of W clocks adds exactly W.
- R9: After a pulse-width measurement stops, the count holds until the next start edge.
- R10: An advance from all ones loads the preload register (address 1) into the counter instead of zero, and counting continues.
- R11: An overflow while `irq_en` is 1 sets `irq_req`. The flag stays set until `irq_clr` is pulsed, and it reads as bit 0 at address 3.
- R12: With `irq_en` at 0, an overflow leaves `irq_req` clear but still reloads the counter.
- R13: A write to the preload register also loads the counter when the enable bit is 0. When the enable bit is 1, the counter is left alone.
- R14: A write to address 2 loads the counter directly. It takes priority over any advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_in | input | 1 | External event / pulse pin, asynchronous |
| rtc_in | input | 1 | Real-time clock tick level, asynchronous |
| tbase_in | input | 1 | Time-base tick level, asynchronous |
| src_sel | input | 2 | Tick source: 0 clock, 1 clock/4, 2 rtc falling, 3 time-base falling |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 preload, 2 counter |
| wr_data | input | WIDTH | Write data |
| rd_addr | input | 2 | Read address: 0 control, 1 preload, 2 counter, 3 status |
| rd_data | output | WIDTH | Combinational read data |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clears the sticky interrupt flag |
| irq_req | output | 1 | Sticky overflow interrupt request |

## Verification
Register writes take effect on the edge that samples the strobe, so the bench reads them back at the following falling clock edge. Any result caused by a pin passes through two synchronizer flops and one edge-history flop, and so is due on the third rising edge after the pin changes. The bench checks that the count is still unchanged after two edges and has changed after the third. Timer counts in clock mode move one per edge from the edge after the enabling write. The bench therefore measures deltas over known numbers of edges, including a divide-by-four window whose length is a multiple of four and so does not depend on phase. All sampling happens at falling edges, half a period away from any update.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

   typedef enum logic [1:0] {
      MODE_OFF   = 2'b00,
      MODE_EVENT = 2'b01,
      MODE_TIMER = 2'b10,
      MODE_PULSE = 2'b11
   } mtc_mode_e;

   typedef enum logic [1:0] {
      SRC_SYS     = 2'd0,
      SRC_SYS_DIV = 2'd1,
      SRC_RTC     = 2'd2,
      SRC_TBASE   = 2'd3
   } mtc_src_e;

   localparam logic [1:0] REG_CTRL    = 2'd0;
   localparam logic [1:0] REG_PRELOAD = 2'd1;
   localparam logic [1:0] REG_COUNT   = 2'd2;
   localparam logic [1:0] REG_STATUS  = 2'd3;

   localparam int CTRL_BITS     = 8;
   localparam int CTRL_EN       = 4;
   localparam int CTRL_EVT_FALL = 3;
   localparam int CTRL_PW_HIGH  = 2;

   typedef struct packed {
      mtc_mode_e mode;
      logic      enable;
      logic      evt_fall;
      logic      pw_high;
   } mtc_ctrl_t;

   function automatic logic [CTRL_BITS-1:0] ctrl_pack(input mtc_ctrl_t c);
      logic [CTRL_BITS-1:0] b;
      b                = '0;
      b[7:6]           = c.mode;
      b[CTRL_EN]       = c.enable;
      b[CTRL_EVT_FALL] = c.evt_fall;
      b[CTRL_PW_HIGH]  = c.pw_high;
      return b;
   endfunction

   function automatic mtc_ctrl_t ctrl_unpack(input logic [CTRL_BITS-1:0] b);
      mtc_ctrl_t c;
      c.mode     = mtc_mode_e'(b[7:6]);
      c.enable   = b[CTRL_EN];
      c.evt_fall = b[CTRL_EVT_FALL];
      c.pw_high  = b[CTRL_PW_HIGH];
      return c;
   endfunction

endpackage

// File: rtl/mtc_sync_pair.sv
module mtc_sync_pair #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic level_d
);

   if (STAGES < 2) begin : g_bad_stages
      $error("mtc_sync_pair: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q   <= '0;
         level_d <= 1'b0;
      end else begin
         stg_q   <= {stg_q[STAGES-2:0], din};
         level_d <= stg_q[STAGES-1];
      end
   end

   assign level = stg_q[STAGES-1];

endmodule

// File: rtl/mtc_tick_gen.sv
module mtc_tick_gen
   import mtc_pkg::*;
#(
   parameter int DIV    = 4,
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] src_sel,
   input  logic       rtc_in,
   input  logic       tbase_in,
   output logic       tick
);

   if (DIV < 1) begin : g_bad_div
      $error("mtc_tick_gen: DIV must be at least 1");
   end

   logic rtc_lvl, rtc_lvl_d, tb_lvl, tb_lvl_d;
   logic rtc_fall, tb_fall, div_tick;

   mtc_sync_pair #(.STAGES(STAGES)) u_rtc_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (rtc_in),
      .level   (rtc_lvl),
      .level_d (rtc_lvl_d)
   );

   mtc_sync_pair #(.STAGES(STAGES)) u_tb_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (tbase_in),
      .level   (tb_lvl),
      .level_d (tb_lvl_d)
   );

   assign rtc_fall = rtc_lvl_d & ~rtc_lvl;
   assign tb_fall  = tb_lvl_d & ~tb_lvl;

   if (DIV == 1) begin : g_div_bypass
      assign div_tick = 1'b1;
   end else begin : g_div_count
      localparam int DW = $clog2(DIV);
      localparam logic [DW-1:0] LAST = DW'(DIV - 1);
      logic [DW-1:0] dcnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              dcnt_q <= '0;
         else if (dcnt_q == LAST) dcnt_q <= '0;
         else                     dcnt_q <= dcnt_q + 1'b1;
      end
      assign div_tick = (dcnt_q == LAST);
   end

   always_comb begin
      case (mtc_src_e'(src_sel))
         SRC_SYS:     tick = 1'b1;
         SRC_SYS_DIV: tick = div_tick;
         SRC_RTC:     tick = rtc_fall;
         SRC_TBASE:   tick = tb_fall;
         default:     tick = 1'b0;
      endcase
   end

endmodule

// File: rtl/mtc_count_core.sv
module mtc_count_core #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   input  logic [WIDTH-1:0] preload,
   output logic [WIDTH-1:0] count,
   output logic             wrap
);

   localparam logic [WIDTH-1:0] FULL = '1;

   assign wrap = inc && !load && (count == FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             count <= '0;
      else if (load)          count <= load_val;
      else if (inc) begin
         if (count == FULL)   count <= preload;
         else                 count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/mtc_top.sv
module mtc_top
   import mtc_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int SYS_DIV     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_in,
   input  logic             rtc_in,
   input  logic             tbase_in,
   input  logic [1:0]       src_sel,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [1:0]       rd_addr,
   output logic [WIDTH-1:0] rd_data,
   input  logic             irq_en,
   input  logic             irq_clr,
   output logic             irq_req
);

   if (WIDTH < CTRL_BITS) begin : g_bad_width
      $error("mtc_top: WIDTH must be at least the control register width");
   end

   mtc_ctrl_t        ctrl_q;
   logic [WIDTH-1:0] preload_q;
   logic [WIDTH-1:0] count_q;
   logic             irq_q;
   logic             pw_active_q;

   logic wr_ctrl, wr_preload, wr_count;
   assign wr_ctrl    = wr_en && (wr_addr == REG_CTRL);
   assign wr_preload = wr_en && (wr_addr == REG_PRELOAD);
   assign wr_count   = wr_en && (wr_addr == REG_COUNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         preload_q <= '0;
      end else begin
         if (wr_ctrl)    ctrl_q    <= ctrl_unpack(wr_data[CTRL_BITS-1:0]);
         if (wr_preload) preload_q <= wr_data;
      end
   end

   // external pin: synchronize, then compare with the previous level
   logic ext_lvl, ext_lvl_d, ext_rise, ext_fall;

   mtc_sync_pair #(.STAGES(SYNC_STAGES)) u_ext_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (ext_in),
      .level   (ext_lvl),
      .level_d (ext_lvl_d)
   );

   assign ext_rise = ext_lvl & ~ext_lvl_d;
   assign ext_fall = ~ext_lvl & ext_lvl_d;

   logic evt_hit, pw_start, pw_stop;
   assign evt_hit  = ctrl_q.evt_fall ? ext_fall : ext_rise;
   assign pw_start = ctrl_q.pw_high  ? ext_rise : ext_fall;
   assign pw_stop  = ctrl_q.pw_high  ? ext_fall : ext_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         pw_active_q <= 1'b0;
      else if (ctrl_q.mode != MODE_PULSE) pw_active_q <= 1'b0;
      else if (pw_start)                  pw_active_q <= 1'b1;
      else if (pw_stop)                   pw_active_q <= 1'b0;
   end

   logic tick;

   mtc_tick_gen #(.DIV(SYS_DIV), .STAGES(SYNC_STAGES)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_sel  (src_sel),
      .rtc_in   (rtc_in),
      .tbase_in (tbase_in),
      .tick     (tick)
   );

   logic inc;
   always_comb begin
      inc = 1'b0;
      if (ctrl_q.enable) begin
         case (ctrl_q.mode)
            MODE_EVENT: inc = evt_hit;
            MODE_TIMER: inc = tick;
            MODE_PULSE: inc = pw_active_q && tick;
            default:    inc = 1'b0;
         endcase
      end
   end

   logic cnt_load, cnt_wrap;
   assign cnt_load = wr_count || (wr_preload && !ctrl_q.enable);

   mtc_count_core #(.WIDTH(WIDTH)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (inc),
      .load     (cnt_load),
      .load_val (wr_data),
      .preload  (preload_q),
      .count    (count_q),
      .wrap     (cnt_wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  irq_q <= 1'b0;
      else if (cnt_wrap && irq_en) irq_q <= 1'b1;
      else if (irq_clr)            irq_q <= 1'b0;
   end

   assign irq_req = irq_q;

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         REG_CTRL:    rd_data[CTRL_BITS-1:0] = ctrl_pack(ctrl_q);
         REG_PRELOAD: rd_data = preload_q;
         REG_COUNT:   rd_data = count_q;
         REG_STATUS:  rd_data[0] = irq_q;
         default:     rd_data = '0;
      endcase
   end

endmodule

// File: rtl/mtc_checker.sv
module mtc_checker #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] count,
   input logic [WIDTH-1:0] preload,
   input logic [WIDTH-1:0] rd_data,
   input logic [1:0]       mode,
   input logic [1:0]       rd_addr,
   input logic             en,
   input logic             wr_en,
   input logic             irq_en,
   input logic             irq_clr,
   input logic             irq_req
);

   localparam logic [WIDTH-1:0] FULL = '1;

   assert_ctrl_unimpl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == 2'd0) |-> (rd_data[5] == 1'b0 && rd_data[1:0] == 2'b00));

   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00 && !wr_en) |=> (count == $past(count)));

   assert_disabled_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !wr_en) |=> (count == $past(count)));

   assert_step_or_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en) |=> ((count == $past(count))
                 || ($past(count) != FULL && count == WIDTH'($past(count) + 1'b1))
                 || ($past(count) == FULL && count == $past(preload))));

   assert_irq_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !irq_clr) |=> irq_req);

   assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> ($past(count) == FULL));

   assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_en && !irq_req) |=> !irq_req);

endmodule

bind mtc_top mtc_checker #(.WIDTH(WIDTH)) u_mtc_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .count   (count_q),
   .preload (preload_q),
   .rd_data (rd_data),
   .mode    (ctrl_q.mode),
   .rd_addr (rd_addr),
   .en      (ctrl_q.enable),
   .wr_en   (wr_en),
   .irq_en  (irq_en),
   .irq_clr (irq_clr),
   .irq_req (irq_req)
);

// File: tb/mtc_top_test.sv
module mtc_top_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       ext_in, rtc_in, tbase_in;
   logic [1:0] src_sel;
   logic       wr_en;
   logic [1:0] wr_addr;
   logic [7:0] wr_data;
   logic [1:0] rd_addr;
   logic [7:0] rd_data;
   logic       irq_en, irq_clr, irq_req;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #10 clk = ~clk;

   mtc_top uut (
      .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .rtc_in(rtc_in),
      .tbase_in(tbase_in), .src_sel(src_sel), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .irq_en(irq_en), .irq_clr(irq_clr),
      .irq_req(irq_req)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   initial begin
      logic [7:0] v, c0, c1, c2;
      int widths_hi [6] = '{1, 2, 3, 7, 20, 33};
      int widths_lo [3] = '{1, 4, 9};
      rst_n = 1'b0; ext_in = 0; rtc_in = 0; tbase_in = 0; src_sel = 0;
      wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0; irq_en = 0; irq_clr = 0;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
      rd(2'd1, v); chk("R1 preload", v, 8'h00);
      rd(2'd2, v); chk("R1 count", v, 8'h00);
      chk("R1 irq", irq_req, 0);

      // R2 control layout and unimplemented bits
      wr(2'd0, 8'hFF); rd(2'd0, v); chk("R2 all ones", v, 8'hDC);
      wr(2'd0, 8'h23); rd(2'd0, v); chk("R2 unimpl only", v, 8'h00);

      // R14 direct counter write
      wr(2'd2, 8'h20); rd(2'd2, v); chk("R14 count write", v, 8'h20);

      // R3 mode 00 with enable set
      wr(2'd0, 8'h10);
      for (int i = 0; i < 3; i++) begin
         ext_in = 1; rtc_in = 1; idle(3); ext_in = 0; rtc_in = 0; idle(3);
      end
      rd(2'd2, v); chk("R3 idle mode hold", v, 8'h20);

      // R6 timer, system clock source, several windows
      src_sel = 2'd0;
      wr(2'd0, 8'h90);
      foreach (widths_hi[k]) begin
         rd(2'd2, c0); idle(widths_hi[k]); rd(2'd2, c1);
         chk("R6 sysclk delta", 8'(c1 - c0), 8'(widths_hi[k]));
      end
      // R6 divide by four: 40 edges give 10 ticks at any phase
      src_sel = 2'd1;
      rd(2'd2, c0); idle(40); rd(2'd2, c1);
      chk("R6 div4 delta", 8'(c1 - c0), 8'd10);
      // R6 rtc falling transitions, time-base ignored
      src_sel = 2'd2;
      rd(2'd2, c0);
      for (int i = 0; i < 4; i++) begin
         rtc_in = 1; tbase_in = 1; idle(3); rtc_in = 0; tbase_in = 0; idle(3);
      end
      idle(2); rd(2'd2, c1);
      chk("R6 rtc delta", 8'(c1 - c0), 8'd4);
      // R6 time-base falling transitions, rtc ignored
      src_sel = 2'd3;
      rd(2'd2, c0);
      for (int i = 0; i < 3; i++) begin
         rtc_in = 1; tbase_in = 1; idle(3); rtc_in = 0; tbase_in = 0; idle(3);
      end
      idle(2); rd(2'd2, c1);
      chk("R6 tbase delta", 8'(c1 - c0), 8'd3);
      src_sel = 2'd0;
      wr(2'd0, 8'h00);

      // R4 enable clear holds in every mode
      wr(2'd0, 8'h80); rd(2'd2, c0); idle(20); rd(2'd2, c1);
      chk("R4 timer disabled", c1, c0);
      wr(2'd0, 8'h40);
      for (int i = 0; i < 3; i++) begin ext_in = 1; idle(3); ext_in = 0; idle(3); end
      rd(2'd2, c1); chk("R4 event disabled", c1, c0);
      wr(2'd0, 8'hC4);
      ext_in = 1; idle(5); ext_in = 0; idle(5);
      rd(2'd2, c1); chk("R4 pulse disabled", c1, c0);

      // R5 rising-edge event counting and its latency
      wr(2'd0, 8'h50); rd(2'd2, c0);
      ext_in = 1; idle(2); rd(2'd2, v); chk("R5 rise not yet", v, c0);
      idle(1); rd(2'd2, v); chk("R5 rise third edge", v, 8'(c0 + 1));
      ext_in = 0; idle(4); rd(2'd2, v); chk("R5 fall ignored", v, 8'(c0 + 1));
      for (int p = 1; p <= 5; p++) begin
         rd(2'd2, c0);
         for (int i = 0; i < p; i++) begin ext_in = 1; idle(2); ext_in = 0; idle(2); end
         idle(2); rd(2'd2, c1);
         chk("R5 rise pulses", 8'(c1 - c0), 8'(p));
      end
      // R5 falling-edge event counting
      wr(2'd0, 8'h58); rd(2'd2, c0);
      ext_in = 1; idle(4); rd(2'd2, v); chk("R5 rise ignored", v, c0);
      ext_in = 0; idle(2); rd(2'd2, v); chk("R5 fall not yet", v, c0);
      idle(1); rd(2'd2, v); chk("R5 fall third edge", v, 8'(c0 + 1));

      // R7 high pulse measurement, R9 hold between pulses
      wr(2'd0, 8'h00); ext_in = 0; idle(4);
      wr(2'd0, 8'hD4);
      foreach (widths_hi[k]) begin
         rd(2'd2, c0);
         ext_in = 1; idle(widths_hi[k]); ext_in = 0; idle(6);
         rd(2'd2, c1);
         chk("R7 high width", 8'(c1 - c0), 8'(widths_hi[k]));
         idle(10); rd(2'd2, c2);
         chk("R9 hold after stop", c2, c1);
      end

      // R8 low pulse measurement
      wr(2'd0, 8'h00); ext_in = 1; idle(4);
      wr(2'd0, 8'hD0);
      foreach (widths_lo[k]) begin
         rd(2'd2, c0);
         ext_in = 0; idle(widths_lo[k]); ext_in = 1; idle(6);
         rd(2'd2, c1);
         chk("R8 low width", 8'(c1 - c0), 8'(widths_lo[k]));
         idle(8); rd(2'd2, c2);
         chk("R9 hold after low stop", c2, c1);
      end
      wr(2'd0, 8'h00); ext_in = 0; idle(4);

      // R13 preload write while disabled loads the counter
      wr(2'd1, 8'h80);
      rd(2'd2, v); chk("R13 disabled load count", v, 8'h80);
      rd(2'd1, v); chk("R13 preload value", v, 8'h80);

      // R10 / R11 overflow reload and sticky interrupt
      irq_en = 1;
      wr(2'd2, 8'hFD);
      wr(2'd0, 8'h90);
      idle(1); rd(2'd2, v); chk("R10 FE", v, 8'hFE);
      idle(1); rd(2'd2, v); chk("R10 FF", v, 8'hFF);
      chk("R11 no irq before wrap", irq_req, 0);
      idle(1); rd(2'd2, v); chk("R10 reload", v, 8'h80);
      chk("R11 irq set", irq_req, 1);
      wr(2'd0, 8'h00);
      idle(5); chk("R11 irq sticky", irq_req, 1);
      rd(2'd3, v); chk("R11 status bit", v, 8'h01);
      irq_clr = 1; idle(1); irq_clr = 0;
      chk("R11 irq cleared", irq_req, 0);

      // R12 masked interrupt, reload still happens
      irq_en = 0;
      wr(2'd1, 8'h10);
      wr(2'd2, 8'hFE);
      wr(2'd0, 8'h90);
      idle(1); rd(2'd2, v); chk("R12 FF", v, 8'hFF);
      idle(1); rd(2'd2, v); chk("R12 reload", v, 8'h10);
      wr(2'd0, 8'h00); idle(3);
      chk("R12 irq stays low", irq_req, 0);

      // R13 preload write while enabled leaves the counter
      wr(2'd0, 8'h50); rd(2'd2, c0);
      wr(2'd1, 8'h33);
      rd(2'd2, v); chk("R13 enabled no load", v, c0);
      rd(2'd1, v); chk("R13 enabled preload", v, 8'h33);

      // R14 counter write wins over an advance in the same cycle
      src_sel = 2'd0; wr(2'd0, 8'h90);
      wr(2'd2, 8'h55);
      rd(2'd2, v); chk("R14 write priority", v, 8'h55);
      wr(2'd0, 8'h00);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule